// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block merges three interrupt events of a real-time clock into one status register and one active-low interrupt request. The three events are an alarm match, a periodic tick and the end of an update. Each event is a single-cycle pulse from timekeeping logic elsewhere on the chip. The block sets the matching flag whenever the pulse arrives, whether or not that source is enabled. Software can therefore poll the flags with every interrupt disabled.

A small processor bus with chip-select, read-enable, write-enable and a one-bit address reaches two registers:

- A control register that holds one enable bit per source.
- A status register that holds the three flags and a summary bit. The summary bit mirrors the interrupt line.

Reading the status register clears it. While a status read is in progress, the flag register is frozen, so the value on the bus cannot change under the reader. Any event that lands during the read is parked in a pending register. The pending events are applied on the clock edge that ends the read, so no event is lost.

Top module: `rtc_irq_flags`

## Requirements
- R1: After reset all flags and enables are 0, `irq_n` is 1, and reading either register returns 0x00.
- R2: A pulse on an event input sets its flag on the next clock edge whatever its enable bit holds. The flags sit in the status register as follows: periodic at bit 6, alarm at bit 5, update-ended at bit 4.
- R3: A write with address 0 loads the enables from `wdata` bits 6 (periodic), 5 (alarm) and 4 (update-ended). A read with address 0 returns those bits in place, with every other bit 0.
- R4: `irq_n` is 0 exactly when some source has both its flag and its enable set. If a flag is already set when its enable is written to 1, `irq_n` falls on the clock edge that takes the write.
- R5: Status bit 7 reads 1 exactly when `irq_n` is 0, and status bits 3..0 always read 0.
- R6: A status read (`cs`, `rd` high and address 1) clears all flags, and with them bit 7 and the request. The clear happens on the first clock edge after the read ends.
- R7: While a status read stays active, the status value on `rdata` does not change, even when events arrive.
- R8: An event that arrives during a status read is set into its flag on the edge that ends the read, and is not cleared by that read.
- R9: Any subset of the three flags, from none to all of them, can be set at once and reads back together in one status read.
- R10: A write with address 1 has no effect on the flags or enables.
- R11: Reading the control register does not clear any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip-select, active high |
| rd | input | 1 | Read-enable, active high |
| wr | input | 1 | Write-enable, active high |
| addr | input | 1 | Register select: 0 control, 1 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read is active |
| ev_alarm | input | 1 | Alarm event pulse |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_update | input | 1 | Update-ended event pulse |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its default three sources at flag bits 6..4, so each of the enable mask and the event pattern has only eight values. The bench sweeps all 64 pairs of enable mask and flag pattern. For each pair it computes the status byte and the interrupt level arithmetically, and it checks them along with the clear-on-read. It also sweeps all eight event patterns arriving in the middle of a multi-cycle read. This covers the stable read value, the held events and their release at the end of the read, for every mix of sources.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int NSRC     = 3;
  localparam int FLAG_LSB = 4;
  localparam int IRQF_BIT = 7;

  // Source order inside the flag vector: index 0 update-ended, 1 alarm, 2 periodic
  localparam int SRC_UPDATE   = 0;
  localparam int SRC_ALARM    = 1;
  localparam int SRC_PERIODIC = 2;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} reg_sel_e;

  function automatic logic [DATA_W-1:0] pack_status(input logic [NSRC-1:0] flags,
                                                    input logic [NSRC-1:0] en);
    logic [DATA_W-1:0] v;
    v = '0;
    v[FLAG_LSB +: NSRC] = flags;
    v[IRQF_BIT] = |(flags & en);
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic [NSRC-1:0] en);
    logic [DATA_W-1:0] v;
    v = '0;
    v[FLAG_LSB +: NSRC] = en;
    return v;
  endfunction
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
  import rtc_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic rd,
  input  logic wr,
  input  logic addr,
  output logic wr_ctrl,
  output logic rd_ctrl,
  output logic rd_stat,
  output logic rd_stat_end
);
  logic rd_stat_q;

  always_comb begin
    wr_ctrl = cs && wr && (addr == SEL_CTRL);
    rd_ctrl = cs && rd && (addr == SEL_CTRL);
    rd_stat = cs && rd && (addr == SEL_STAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_stat_q <= 1'b0;
    else        rd_stat_q <= rd_stat;
  end

  // first cycle in which a status read that was seen at an edge is gone
  assign rd_stat_end = rd_stat_q && !rd_stat;
endmodule

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic hold,
  input  logic release_now,
  output logic flag,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      pend <= 1'b0;
    end else if (hold) begin
      pend <= pend | ev;
    end else if (release_now) begin
      flag <= pend | ev;
      pend <= 1'b0;
    end else begin
      flag <= flag | ev;
    end
  end
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
  import rtc_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         hold,
  input  logic         release_now,
  output logic [N-1:0] flags,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_src
    rtc_flag_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev         (ev[i]),
      .hold       (hold),
      .release_now(release_now),
      .flag       (flags[i]),
      .pend       (pend[i])
    );
  end
endmodule

// File: rtl/rtc_irq_gate.sv
module rtc_irq_gate
  import rtc_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ctrl,
  input  logic [N-1:0] en_wdata,
  input  logic [N-1:0] flags,
  output logic [N-1:0] en,
  output logic         irq_any
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en <= '0;
    else if (wr_ctrl) en <= en_wdata;
  end

  assign irq_any = |(flags & en);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ev_alarm,
  input  logic              ev_periodic,
  input  logic              ev_update,
  output logic              irq_n
);
  logic            wr_ctrl, rd_ctrl, rd_stat, rd_stat_end;
  logic [NSRC-1:0] ev_vec, flags, pend, en;
  logic            irq_any;

  always_comb begin
    ev_vec               = '0;
    ev_vec[SRC_UPDATE]   = ev_update;
    ev_vec[SRC_ALARM]    = ev_alarm;
    ev_vec[SRC_PERIODIC] = ev_periodic;
  end

  rtc_bus_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wr_ctrl(wr_ctrl), .rd_ctrl(rd_ctrl), .rd_stat(rd_stat), .rd_stat_end(rd_stat_end)
  );

  rtc_flag_bank #(.N(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .hold(rd_stat),
    .release_now(rd_stat_end), .flags(flags), .pend(pend)
  );

  rtc_irq_gate #(.N(NSRC)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
    .en_wdata(wdata[FLAG_LSB +: NSRC]), .flags(flags),
    .en(en), .irq_any(irq_any)
  );

  always_comb begin
    if (rd_stat)      rdata = pack_status(flags, en);
    else if (rd_ctrl) rdata = pack_ctrl(en);
    else              rdata = '0;
  end

  assign irq_n = ~irq_any;
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk
  import rtc_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stat,
  input logic              rd_stat_end,
  input logic [NSRC-1:0]   ev_vec,
  input logic [NSRC-1:0]   flags,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   en,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_n
);
  assert_stable_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && $past(rd_stat) |-> $stable(flags));

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec != '0) && !rd_stat && !rd_stat_end |=> ((flags & $past(ev_vec)) == $past(ev_vec)));

  assert_held_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && (ev_vec != '0) |=> ((pend & $past(ev_vec)) == $past(ev_vec)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat_end |=> (flags == $past(pend | ev_vec)));

  assert_no_enable_no_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> irq_n);

  always_comb begin
    if (rst_n && rd_stat)
      assert_irqf_mirror_R5: assert (rdata[IRQF_BIT] == !irq_n && rdata[3:0] == 4'h0);
  end
endmodule

bind rtc_irq_flags rtc_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .rd_stat_end(rd_stat_end),
  .ev_vec(ev_vec), .flags(flags), .pend(pend), .en(en), .rdata(rdata), .irq_n(irq_n)
);

// File: tb/tb_rtc_irq_flags.sv
module tb_rtc_irq_flags;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 0, rd = 0, wr = 0, addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       ev_alarm = 0, ev_periodic = 0, ev_update = 0;
  logic       irq_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  rtc_irq_flags dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ev_alarm(ev_alarm), .ev_periodic(ev_periodic),
    .ev_update(ev_update), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // pattern p: bit2 periodic, bit1 alarm, bit0 update -> status bits 6,5,4
  function automatic logic [7:0] exp_stat(input int p, input int e);
    return 8'((((p & e) != 0) ? 128 : 0) + p * 16);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic pulse(input int p);
    @(negedge clk);
    ev_update = p[0]; ev_alarm = p[1]; ev_periodic = p[2];
    @(negedge clk);
    ev_update = 0; ev_alarm = 0; ev_periodic = 0;
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0; wdata = 0;
  endtask

  // one-cycle read; returns value seen; clear lands one edge later
  task automatic read_reg(input logic a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    @(negedge clk);
    d = rdata;
    cs = 0; rd = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, first;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_n", {7'd0, irq_n}, 8'd1);
    read_reg(1'b1, v); check("R1 status", v, 8'h00);
    read_reg(1'b0, v); check("R1 control", v, 8'h00);

    // R2 R3 R4 R5 R6 R9 sweep of enable mask x flag pattern
    for (int e = 0; e < 8; e++) begin
      write_reg(1'b0, 8'(e * 16) | 8'h8F);
      read_reg(1'b0, v); check("R3 ctrl readback", v, 8'(e * 16));
      for (int p = 0; p < 8; p++) begin
        pulse(p);
        check("R4 irq level", {7'd0, irq_n}, {7'd0, !((p & e) != 0)});
        read_reg(1'b0, v);  // R11 control read leaves flags
        read_reg(1'b1, v);
        check("R2 R5 R9 status", v, exp_stat(p, e));
        check("R6 irq after clear", {7'd0, irq_n}, 8'd1);
        read_reg(1'b1, v);
        check("R6 cleared", v, 8'h00);
      end
    end

    // R11 control read does not clear
    write_reg(1'b0, 8'h00);
    pulse(3'b101);
    read_reg(1'b0, v);
    read_reg(1'b1, v); check("R11 flags kept", v, exp_stat(5, 0));

    // R4 enable after flag set: irq at the write edge
    pulse(3'b010);
    @(negedge clk);
    cs = 1; wr = 1; addr = 0; wdata = 8'h20;
    @(negedge clk);
    check("R4 late enable", {7'd0, irq_n}, 8'd0);
    cs = 0; wr = 0;
    read_reg(1'b1, v); check("R4 R5 late enable status", v, 8'hA0);

    // R10 write to status address ignored
    write_reg(1'b0, 8'h70);
    pulse(3'b001);
    write_reg(1'b1, 8'h00);
    check("R10 irq unchanged", {7'd0, irq_n}, 8'd0);
    read_reg(1'b1, v); check("R10 flags kept", v, exp_stat(1, 7));
    read_reg(1'b0, v); check("R10 enables kept", v, 8'h70);

    // R7 R8 events mid-read, all patterns
    for (int p = 0; p < 8; p++) begin
      pulse(3'b100);
      @(negedge clk);
      cs = 1; rd = 1; addr = 1;
      #1 first = rdata;
      check("R7 first", first, exp_stat(4, 7));
      @(negedge clk);
      ev_update = p[0]; ev_alarm = p[1]; ev_periodic = p[2];
      @(negedge clk);
      ev_update = 0; ev_alarm = 0; ev_periodic = 0;
      check("R7 stable", rdata, first);
      @(negedge clk);
      check("R7 stable late", rdata, first);
      cs = 0; rd = 0;
      @(negedge clk);
      check("R8 irq after read", {7'd0, irq_n}, {7'd0, !(p != 0)});
      read_reg(1'b1, v); check("R8 held events", v, exp_stat(p, 7));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule